// File: doc/BRIEF.md
# Lookahead Adder-Subtractor Unit

This block is one arithmetic slice of a datapath. It adds, subtracts or increments two `W`-bit operands, and a two-bit operation code picks the operation. The adder is a two-level carry-lookahead structure. Bit-level propagate and generate terms feed groups of `G` bits. Each group reports a group generate and a group propagate. A second lookahead stage, built from the same group module, computes the carry into every group in parallel.

Subtraction reuses the adder without any extra carry logic. The B operand is inverted and the initial carry is forced high, so the adder forms A + ~B + 1. Increment takes a separate, much smaller path. With the second operand fixed at one, every carry collapses to the AND of the operand bits below it.

All outputs are registered. A result appears one clock after its operands are presented. A synchronous active-high reset clears the outputs. `W` must be a whole multiple of `G`.

Top module: `addsub_lookahead`

## Requirements
- R1: With `op_mode` = 2'b00, `result` is (opa + opb + cin) mod 2^W and `carry_out` is bit W of that sum.
- R2: The code `op_mode` = 2'b11 behaves exactly as 2'b00.
- R3: With `op_mode` = 2'b01, `result` is (opa − opb) mod 2^W, `carry_out` is 1 exactly when opa ≥ opb as unsigned values, and `cin` has no effect.
- R4: `borrow` equals the inverse of `carry_out` when `op_mode` = 2'b01 and is 0 for every other code.
- R5: With `op_mode` = 2'b10, `result` is (opa + 1) mod 2^W, `carry_out` is the AND of all bits of opa, and `opb` and `cin` have no effect.
- R6: Incrementing an all-ones operand gives an all-zeros `result` with `carry_out` = 1.
- R7: `overflow` is the XOR of the carry into bit W−1 and the carry out of bit W−1 for the selected operation, i.e. the two's-complement overflow of that operation.
- R8: The outputs take the value for the operands presented before a rising clock edge at that edge; while `rst` is high at an edge, all outputs become 0.
- R9: Subtracting equal operands gives `result` = 0, `carry_out` = 1 and `borrow` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_mode | input | 2 | 00 add, 01 subtract, 10 increment, 11 add |
| opa | input | W | First operand |
| opb | input | W | Second operand (ignored on increment) |
| cin | input | 1 | Carry-in for add codes |
| result | output | W | Registered result |
| carry_out | output | 1 | Registered carry out of the top bit |
| borrow | output | 1 | Registered borrow flag, subtract only |
| overflow | output | 1 | Registered signed overflow flag |

## Verification
Several flags settle in the same registered cycle and can conflict: a signed overflow, an unsigned carry or borrow, and a result of zero. For example, 0x8000 − 0x0001 must raise overflow with no borrow, and 0xFFFF + 1 must give carry with zero and no overflow. The bench drives directed operands that make these flags coincide. It also applies random streams in every code, with `cin` and `opb` set to random values where they must be ignored. Each cycle it compares the registered outputs against an independent arithmetic model, one cycle behind the stimulus.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    MD_ADD     = 2'b00,
    MD_SUB     = 2'b01,
    MD_INC     = 2'b10,
    MD_ADD_ALT = 2'b11
  } md_t;
endpackage

// File: rtl/lka_group.sv
// Generic lookahead block: carries into each of G positions from p/g and a
// carry-in, plus group generate/propagate. Used at bit and at group level.
module lka_group #(
  parameter int G = 4
) (
  input  logic [G-1:0] p,
  input  logic [G-1:0] g,
  input  logic         cin,
  output logic [G-1:0] cin_bit,
  output logic         grp_g,
  output logic         grp_p
);
  logic term;
  logic acc;

  always_comb begin
    cin_bit = '0;
    for (int i = 0; i < G; i++) begin
      term = cin;
      for (int k = 0; k < i; k++) term = term & p[k];
      acc = term;
      for (int j = 0; j < i; j++) begin
        term = g[j];
        for (int k = j + 1; k < i; k++) term = term & p[k];
        acc = acc | term;
      end
      cin_bit[i] = acc;
    end
    grp_p = &p;
    acc = 1'b0;
    for (int j = 0; j < G; j++) begin
      term = g[j];
      for (int k = j + 1; k < G; k++) term = term & p[k];
      acc = acc | term;
    end
    grp_g = acc;
  end
endmodule

// File: rtl/lka_adder.sv
// Two-level lookahead adder: groups of G bits, second level over the groups.
module lka_adder #(
  parameter int W = 16,
  parameter int G = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c0,
  output logic [W-1:0] sum,
  output logic [W:0]   carry
);
  localparam int NG = W / G;

  logic [W-1:0]  p_bit, g_bit, c_bit;
  logic [NG-1:0] gg_v, gp_v, gc_v;
  logic          top_g, top_p;

  assign p_bit = a ^ b;
  assign g_bit = a & b;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    lka_group #(.G(G)) u_grp (
      .p       (p_bit[k*G +: G]),
      .g       (g_bit[k*G +: G]),
      .cin     (gc_v[k]),
      .cin_bit (c_bit[k*G +: G]),
      .grp_g   (gg_v[k]),
      .grp_p   (gp_v[k])
    );
  end

  lka_group #(.G(NG)) u_top (
    .p       (gp_v),
    .g       (gg_v),
    .cin     (c0),
    .cin_bit (gc_v),
    .grp_g   (top_g),
    .grp_p   (top_p)
  );

  assign carry = {top_g | (top_p & c0), c_bit};
  assign sum   = p_bit ^ c_bit;
endmodule

// File: rtl/lka_inc.sv
// Incrementer: each carry is the AND of all operand bits below it.
module lka_inc #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] ic;
  logic       t;

  always_comb begin
    ic[0] = 1'b1;
    for (int k = 1; k <= W; k++) begin
      t = 1'b1;
      for (int j = 0; j < k; j++) t = t & a[j];
      ic[k] = t;
    end
  end

  assign sum  = a ^ ic[W-1:0];
  assign cout = ic[W];
  assign ovf  = ic[W] ^ ic[W-1];
endmodule

// File: rtl/addsub_lookahead.sv
module addsub_lookahead #(
  parameter int W = 16,
  parameter int G = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op_mode,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         borrow,
  output logic         overflow
);
  import addsub_pkg::*;

  md_t         md;
  logic        is_sub, is_inc;
  logic [W-1:0] b_eff, add_sum, inc_sum;
  logic [W:0]  add_c;
  logic        add_c0, inc_cout, inc_ovf;
  logic [W-1:0] nxt_res;
  logic        nxt_cout, nxt_brw, nxt_ovf;

  assign md     = md_t'(op_mode);
  assign is_sub = (md == MD_SUB);
  assign is_inc = (md == MD_INC);
  assign b_eff  = is_sub ? ~opb : opb;
  assign add_c0 = is_sub ? 1'b1 : cin;

  lka_adder #(.W(W), .G(G)) u_add (
    .a     (opa),
    .b     (b_eff),
    .c0    (add_c0),
    .sum   (add_sum),
    .carry (add_c)
  );

  lka_inc #(.W(W)) u_inc (
    .a    (opa),
    .sum  (inc_sum),
    .cout (inc_cout),
    .ovf  (inc_ovf)
  );

  always_comb begin
    if (is_inc) begin
      nxt_res  = inc_sum;
      nxt_cout = inc_cout;
      nxt_ovf  = inc_ovf;
    end else begin
      nxt_res  = add_sum;
      nxt_cout = add_c[W];
      nxt_ovf  = add_c[W] ^ add_c[W-1];
    end
    nxt_brw = is_sub & ~add_c[W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      borrow    <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      result    <= nxt_res;
      carry_out <= nxt_cout;
      borrow    <= nxt_brw;
      overflow  <= nxt_ovf;
    end
  end
endmodule

// File: rtl/addsub_chk.sv
module addsub_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   op_mode,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         borrow,
  input logic         overflow
);
  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_mode) == 2'b01) |-> (borrow == ($past(opa) < $past(opb)))); // R4
  AST_BORROW_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_mode) != 2'b01) |-> !borrow); // R4
  AST_INC_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_mode) == 2'b10) |-> (carry_out == &$past(opa))); // R5
  AST_INC_ROLL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_mode) == 2'b10 && &$past(opa)) |-> (result == '0 && carry_out && !overflow)); // R6
  AST_SUB_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_mode) == 2'b01 && $past(opa) == $past(opb)) |-> (result == '0 && carry_out)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && !carry_out && !borrow && !overflow)); // R8
endmodule

bind addsub_lookahead addsub_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_mode   (op_mode),
  .opa       (opa),
  .opb       (opb),
  .result    (result),
  .carry_out (carry_out),
  .borrow    (borrow),
  .overflow  (overflow)
);

// File: tb/sim_addsub_lookahead.sv
module sim_addsub_lookahead;
  localparam int W      = 16;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   op_mode = 2'b00;
  logic [W-1:0] opa = '0, opb = '0;
  logic         cin = 1'b0;
  logic [W-1:0] result;
  logic         carry_out, borrow, overflow;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [W+2:0] expq[$];
  string        tagq[$];

  always #(PERIOD/2) clk = ~clk;

  addsub_lookahead #(.W(W), .G(4)) u0 (
    .clk(clk), .rst(rst), .op_mode(op_mode), .opa(opa), .opb(opb), .cin(cin),
    .result(result), .carry_out(carry_out), .borrow(borrow), .overflow(overflow)
  );

  // Behavioural model: returns {result, carry, borrow, overflow}
  function automatic logic [W+2:0] model(logic [1:0] m, logic [W-1:0] a, logic [W-1:0] b, logic ci);
    logic [W:0]   s;
    logic [W-1:0] r;
    logic         c, br, ov;
    br = 1'b0;
    case (m)
      2'b01: begin
        r  = a - b;
        c  = (a >= b);
        br = ~c;
        ov = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      2'b10: begin
        r  = a + 1'b1;
        c  = (a == {W{1'b1}});
        ov = (a == {1'b0, {(W-1){1'b1}}});
      end
      default: begin
        s  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        r  = s[W-1:0];
        c  = s[W];
        ov = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
    endcase
    return {r, c, br, ov};
  endfunction

  task automatic check_front();
    logic [W+2:0] e;
    string        t;
    bit           bad;
    if (expq.size() == 0) return;
    e = expq.pop_front();
    t = tagq.pop_front();
    n_vec++;
    bad = 0;
    if (result != e[W+2:3] || carry_out != e[2]) begin
      $display("FAIL %s: result/carry got %h/%b expected %h/%b", t, result, carry_out, e[W+2:3], e[2]);
      bad = 1;
    end
    if (borrow != e[1]) begin
      $display("FAIL R4: borrow got %b expected %b (%s)", borrow, e[1], t);
      bad = 1;
    end
    if (overflow != e[0]) begin
      $display("FAIL R7: overflow got %b expected %b (%s)", overflow, e[0], t);
      bad = 1;
    end
    if (bad) n_bad++;
  endtask

  task automatic step(logic [1:0] m, logic [W-1:0] a, logic [W-1:0] b, logic ci, string t);
    @(negedge clk);
    check_front();
    op_mode = m; opa = a; opb = b; cin = ci;
    expq.push_back(model(m, a, b, ci));
    tagq.push_back(t);
  endtask

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R3";
      2'b10:   return "R5";
      default: return "R2";
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    // R8: outputs cleared under reset
    if (result != '0 || carry_out || borrow || overflow) begin
      $display("FAIL R8: reset outputs got %h %b %b %b expected 0 0 0 0", result, carry_out, borrow, overflow);
      n_bad++;
    end
    opa = 16'hFFFF; opb = 16'hFFFF; op_mode = 2'b00; cin = 1'b1;
    @(negedge clk);
    n_vec++;
    if (result != '0 || carry_out) begin // R8: reset still held, inputs ignored
      $display("FAIL R8: held reset got %h %b expected 0 0", result, carry_out);
      n_bad++;
    end
    rst = 1'b0;

    // R1 add corners
    step(2'b00, 16'h0000, 16'h0000, 1'b0, "R1");
    step(2'b00, 16'hFFFF, 16'h0001, 1'b0, "R1");
    step(2'b00, 16'hFFFF, 16'hFFFF, 1'b1, "R1");
    step(2'b00, 16'h7FFF, 16'h0001, 1'b0, "R1");
    step(2'b00, 16'h8000, 16'h8000, 1'b0, "R1");
    // R2 alternate add code
    step(2'b11, 16'h1234, 16'hEDCB, 1'b1, "R2");
    step(2'b11, 16'h7FFF, 16'h7FFF, 1'b0, "R2");
    // R3 subtract; cin must not matter
    step(2'b01, 16'h0000, 16'h0001, 1'b0, "R3");
    step(2'b01, 16'h0000, 16'h0001, 1'b1, "R3");
    step(2'b01, 16'h8000, 16'h0001, 1'b1, "R3");
    step(2'b01, 16'h7FFF, 16'hFFFF, 1'b0, "R3");
    step(2'b01, 16'h0005, 16'h0003, 1'b1, "R3");
    // R9 equal operands
    step(2'b01, 16'h0000, 16'h0000, 1'b0, "R9");
    step(2'b01, 16'hFFFF, 16'hFFFF, 1'b1, "R9");
    step(2'b01, 16'hA5A5, 16'hA5A5, 1'b0, "R9");
    // R6 roll-over, R5 increment with opb/cin noise
    step(2'b10, 16'hFFFF, 16'h1357, 1'b1, "R6");
    step(2'b10, 16'h7FFF, 16'hFFFF, 1'b1, "R5");
    step(2'b10, 16'h0000, 16'hFFFF, 1'b1, "R5");
    step(2'b10, 16'h00FF, 16'h0000, 1'b0, "R5");

    for (int i = 0; i < 2000; i++) begin
      logic [1:0]   m;
      logic [W-1:0] a, b;
      m = 2'(i % 4);
      a = W'($urandom);
      b = (i % 17 == 0) ? a : W'($urandom);
      step(m, a, b, 1'($urandom), mode_tag(m));
    end
    @(negedge clk);
    check_front();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R8: watchdog expired got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule